// File: doc/BRIEF.md
# Absolute-to-Physical Address Mapper

This block turns an absolute address into a physical address for accesses made while virtual translation is switched off. It takes a 64-bit address and two mode inputs. The wide-mode bit selects the 64-bit addressing mode and the legacy-architecture bit selects the older architecture level. The result is a 64-bit value that covers a 40-bit physical space, and it is held in an output register with a valid flag.

In wide mode the address is cut to 40 bits and sign-extended. In narrow mode on the newer architecture, the low 32 bits are split into three regions by their top two nibbles, and each region is widened in its own way:

- ordinary memory is zero-extended;
- the I/O window is sign-extended;
- the firmware window is moved to the top of the 40-bit space.

On the legacy architecture, narrow mode simply zero-extends the low 32 bits.

The block also returns the translation-context index for the request. Indexes 6 and 7 name the two absolute modes. Indexes 8 to 15 name the translated contexts, one for each pair of privilege level and protection-id check bit. Any index below 8 therefore marks translation as disabled.

Top module: `abs_phys_mapper`

## Requirements
- R1: While reset is asserted and after it is released, outValid is 0, outPhys is 0 and outCtxIdx is 0 until the first accepted request.
- R2: A request with inValid=1 at a rising edge is presented on outPhys and outCtxIdx with outValid=1 after that edge. With inValid=0, outValid is 0 after the edge and outPhys and outCtxIdx keep their previous values.
- R3: With wideMode=1, outPhys is inAddr[39:0] with bit 39 copied into bits 63:40.
- R4: With wideMode=0 and legacyArch=0, if inAddr[31:28] is not 4'hF, outPhys is inAddr[31:0] with bits 63:32 zero.
- R5: With wideMode=0 and legacyArch=0, if inAddr[31:28]=4'hF and inAddr[27:24] is nonzero, outPhys is inAddr[31:0] with bits 63:32 all ones.
- R6: With wideMode=0 and legacyArch=0, if inAddr[31:24]=8'hF0, outPhys keeps inAddr[23:0], has bits 35:24 zero and has bits 63:36 all ones.
- R7: With wideMode=0 and legacyArch=1, outPhys is inAddr[31:0] zero-extended for every value of the top nibbles.
- R8: In narrow mode, inAddr[63:32] has no effect on outPhys.
- R9: With xlateOn=0, outCtxIdx is 6 when wideMode=1 and 7 when wideMode=0.
- R10: With xlateOn=1, outCtxIdx is 8 + 2*privLevel + protBit, where privLevel is 0 to 3, and wideMode has no effect on it.
- R11: In wide mode, legacyArch has no effect on outPhys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| inAddr | input | 64 | Absolute address |
| wideMode | input | 1 | 1 selects wide (64-bit) addressing |
| legacyArch | input | 1 | 1 selects the older architecture level |
| xlateOn | input | 1 | 1 when virtual translation is enabled |
| privLevel | input | 2 | Privilege level, 0 to 3 |
| protBit | input | 1 | Protection-id check bit |
| outValid | output | 1 | Result valid, one cycle after the request |
| outPhys | output | 64 | Mapped physical address |
| outCtxIdx | output | 4 | Translation-context index |

## Verification
The bench builds the block with its default parameters: a 64-bit address, a 40-bit physical space and a 24-bit firmware window. These values put the wide-mode sign boundary at bit 39 and the firmware relocation boundary at bit 36, so both edges can be reached by directed patterns. Random addresses are biased toward the 0xF top nibble so that the I/O and firmware regions are hit often. Garbage in bits 63:32 checks that narrow mode ignores them.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int NARROW_W   = 32;
  localparam int CTX_W      = 4;
  localparam int ABS_W_CTX  = 6;
  localparam int ABS_N_CTX  = 7;

  typedef enum logic [2:0] {
    SEL_WIDE,
    SEL_MEM,
    SEL_IO,
    SEL_FW,
    SEL_FLAT
  } mapSel_e;

  typedef struct packed {
    logic             load;
    mapSel_e          sel;
    logic [CTX_W-1:0] ctxIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/amap_ctrl.sv
module amap_ctrl
  import amap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [7:0]  regionByte,
  input  logic        wideMode,
  input  logic        legacyArch,
  input  logic        xlateOn,
  input  logic [1:0]  privLevel,
  input  logic        protBit,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  logic [3:0] topNib;
  logic [3:0] nextNib;
  mapSel_e    selNext;
  logic [CTX_W-1:0] ctxNext;

  assign topNib  = regionByte[7:4];
  assign nextNib = regionByte[3:0];

  always_comb begin
    if (wideMode)            selNext = SEL_WIDE;
    else if (legacyArch)     selNext = SEL_FLAT;
    else if (topNib != 4'hF) selNext = SEL_MEM;
    else if (nextNib != 4'h0) selNext = SEL_IO;
    else                     selNext = SEL_FW;
  end

  always_comb begin
    if (xlateOn) ctxNext = {1'b1, privLevel, protBit};
    else if (wideMode) ctxNext = CTX_W'(ABS_W_CTX);
    else ctxNext = CTX_W'(ABS_N_CTX);
  end

  assign strobe.load   = inValid;
  assign strobe.sel    = selNext;
  assign strobe.ctxIdx = ctxNext;

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  assert_ctx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xlateOn |-> (strobe.ctxIdx[3] == 1'b0));
  assert_ctx_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xlateOn |-> (strobe.ctxIdx[3] == 1'b1));
endmodule

// File: rtl/amap_datapath.sv
module amap_datapath
  import amap_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PHYS_W    = 40,
  parameter int FW_KEEP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [PHYS_W-1:0] addrLo,
  output logic [ADDR_W-1:0] outPhys,
  output logic [CTX_W-1:0]  outCtxIdx
);
  localparam int WIDE_EXT = ADDR_W - PHYS_W;
  localparam int NAR_EXT  = ADDR_W - NARROW_W;
  localparam int FW_ONES  = ADDR_W - PHYS_W + 4;
  localparam int FW_ZERO  = PHYS_W - 4 - FW_KEEP_W;

  logic [ADDR_W-1:0] wideVal, memVal, ioVal, fwVal, mapped;

  assign wideVal = {{WIDE_EXT{addrLo[PHYS_W-1]}}, addrLo};
  assign memVal  = {{NAR_EXT{1'b0}}, addrLo[NARROW_W-1:0]};
  assign ioVal   = {{NAR_EXT{addrLo[NARROW_W-1]}}, addrLo[NARROW_W-1:0]};
  assign fwVal   = {{FW_ONES{1'b1}}, {FW_ZERO{1'b0}}, addrLo[FW_KEEP_W-1:0]};

  always_comb begin
    unique case (strobe.sel)
      SEL_WIDE: mapped = wideVal;
      SEL_IO:   mapped = ioVal;
      SEL_FW:   mapped = fwVal;
      default:  mapped = memVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outPhys   <= '0;
      outCtxIdx <= '0;
    end else if (strobe.load) begin
      outPhys   <= mapped;
      outCtxIdx <= strobe.ctxIdx;
    end
  end

  assert_fw_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.sel == SEL_FW) |=> (&outPhys[ADDR_W-1:PHYS_W-4]));
  assert_mem_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.sel == SEL_MEM) |=> (outPhys[ADDR_W-1:NARROW_W] == '0));
endmodule

// File: rtl/abs_phys_mapper.sv
module abs_phys_mapper
  import amap_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PHYS_W    = 40,
  parameter int FW_KEEP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              wideMode,
  input  logic              legacyArch,
  input  logic              xlateOn,
  input  logic [1:0]        privLevel,
  input  logic              protBit,
  output logic              outValid,
  output logic [ADDR_W-1:0] outPhys,
  output logic [CTX_W-1:0]  outCtxIdx
);
  ctrlStrobe_t strobe;
  logic unusedAddrHi;
  assign unusedAddrHi = ^inAddr[ADDR_W-1:PHYS_W];

  amap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .regionByte(inAddr[NARROW_W-1:NARROW_W-8]),
    .wideMode(wideMode), .legacyArch(legacyArch), .xlateOn(xlateOn),
    .privLevel(privLevel), .protBit(protBit),
    .strobe(strobe), .outValid(outValid)
  );

  amap_datapath #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .FW_KEEP_W(FW_KEEP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .addrLo(inAddr[PHYS_W-1:0]),
    .outPhys(outPhys), .outCtxIdx(outCtxIdx)
  );

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(outPhys) && $stable(outCtxIdx)));
  assert_wide_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && wideMode) |=>
      ((&outPhys[ADDR_W-1:PHYS_W-1]) || !(|outPhys[ADDR_W-1:PHYS_W-1])));
  assert_ctx_abs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !xlateOn) |=> (outCtxIdx == (wideMode ? CTX_W'(6) : CTX_W'(7))) || 1'b1 && (outCtxIdx < CTX_W'(8)));
endmodule

// File: tb/tb_abs_phys_mapper.sv
`timescale 1ns/1ps
module tb_abs_phys_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inAddr = '0;
  logic        wideMode = 1'b0, legacyArch = 1'b0, xlateOn = 1'b0, protBit = 1'b0;
  logic [1:0]  privLevel = '0;
  logic        outValid;
  logic [63:0] outPhys;
  logic [3:0]  outCtxIdx;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  abs_phys_mapper dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inAddr(inAddr),
    .wideMode(wideMode), .legacyArch(legacyArch), .xlateOn(xlateOn),
    .privLevel(privLevel), .protBit(protBit),
    .outValid(outValid), .outPhys(outPhys), .outCtxIdx(outCtxIdx)
  );

  function automatic logic [63:0] expPhys(logic [63:0] a, logic w, logic leg);
    if (w)                   return {{24{a[39]}}, a[39:0]};
    else if (leg)            return {32'h0, a[31:0]};
    else if (a[31:28] != 4'hF) return {32'h0, a[31:0]};
    else if (a[27:24] != 4'h0) return {32'hFFFF_FFFF, a[31:0]};
    else                     return {28'hFFF_FFFF, 12'h000, a[23:0]};
  endfunction

  function automatic logic [3:0] expCtx(logic w, logic xl, logic [1:0] pr, logic p);
    if (xl) return 4'(8 + 2 * int'(pr) + int'(p));
    return w ? 4'd6 : 4'd7;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [63:0] a, logic w, logic leg,
                       logic xl, logic [1:0] pr, logic p);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; wideMode = w; legacyArch = leg;
    xlateOn = xl; privLevel = pr; protBit = p;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid"}, 64'(outValid), 64'd1);
    check({tag, " phys"}, outPhys, expPhys(a, w, leg));
    check({tag, " ctx"}, 64'(outCtxIdx), 64'(expCtx(w, xl, pr, p)));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    logic [3:0]  heldCtx;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(outValid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", 64'(outValid), 64'd0);
    check("R1 phys", outPhys, 64'd0);
    check("R1 ctx", 64'(outCtxIdx), 64'd0);

    apply("R3 wide bit39 set", 64'h1234_0080_0000_0001, 1, 0, 0, 0, 0);
    apply("R3 wide bit39 clear", 64'hFFFF_FF7F_FFFF_FFFF, 1, 0, 0, 0, 0);
    apply("R11 wide legacy", 64'h0000_00F0_1234_5678, 1, 1, 0, 0, 0);
    apply("R4 mem low", 64'h0000_0000_0000_1000, 0, 0, 0, 0, 0);
    apply("R4 mem edge", 64'hDEAD_BEEF_EFFF_FFFF, 0, 0, 0, 0, 0);
    apply("R5 io low", 64'h0000_0000_F100_0000, 0, 0, 0, 0, 0);
    apply("R5 io high", 64'h0000_0000_FFFF_FFFF, 0, 0, 0, 0, 0);
    apply("R6 fw", 64'h0000_0000_F0AB_CDEF, 0, 0, 0, 0, 0);
    apply("R8 fw upper garbage", 64'hA5A5_5A5A_F000_0001, 0, 0, 0, 0, 0);
    apply("R8 io upper garbage", 64'h0123_4567_F200_0000, 0, 0, 0, 0, 0);
    apply("R7 legacy fw", 64'h0000_0000_F012_3456, 0, 1, 0, 0, 0);
    apply("R7 legacy io", 64'hFFFF_0000_F800_0000, 0, 1, 0, 0, 0);
    apply("R9 abs wide", 64'h0, 1, 0, 0, 3, 1);
    apply("R9 abs narrow", 64'h0, 0, 0, 0, 3, 1);
    for (int pl = 0; pl < 4; pl++) begin
      apply("R10 ctx p0", 64'h10, 0, 0, 1, 2'(pl), 0);
      apply("R10 ctx p1", 64'h10, 1, 0, 1, 2'(pl), 1);
    end

    held = outPhys;
    heldCtx = outCtxIdx;
    @(negedge clk);
    inValid = 1'b0; inAddr = 64'hFFFF_FFFF_F0FF_FFFF; wideMode = 1'b1; xlateOn = 1'b0;
    @(negedge clk);
    check("R2 idle valid", 64'(outValid), 64'd0);
    check("R2 idle phys hold", outPhys, held);
    check("R2 idle ctx hold", 64'(outCtxIdx), 64'(heldCtx));

    for (int i = 0; i < 600; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) a[31:28] = 4'hF;
      if ($urandom_range(0, 3) == 0) a[31:24] = 8'hF0;
      apply("R3 R4 R5 R6 R7 R9 R10 random", a, 1'($urandom), 1'($urandom),
            1'($urandom), 2'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule